// File: doc/BRIEF.md
# Successive Approximation Conversion Engine

This block is the digital sequencer of one successive-approximation analog-to-digital conversion. A start strobe, accepted only while the engine is powered and idle, sets off a fixed schedule counted in conversion clocks. The conversion clock is the bus clock divided by a programmable prescaler. The schedule opens with a sample phase of programmable length, during which an external sample-and-hold tracks its input. The rest of the schedule is sixteen conversion clocks. In those clocks the engine runs a binary search from the most significant bit downward. It presents a trial code to an external DAC and reads back one comparator bit per resolved bit.

The resolution is eight or ten bits. Each resolved bit takes exactly one conversion clock. The unused part of the sixteen clocks is spent as idle padding before the search, so the total duration depends only on the sample setting. Prescaler, sample length and resolution are captured when a start is accepted. Changing them during a conversion therefore has no effect until the next start. Clearing the power enable stops any conversion at once.

Top module: `sar_conv_engine`

## Requirements
- R1: After reset, `busy`, `done`, `sample_en`, `trial_code` and `result` are all zero.
- R2: With `res8_sel`=0, the result is the 10-bit code found by the binary search, right-aligned in `result[9:0]`. Trial bits are kept when `cmp_in`=1, meaning the held input is at or above the trial code. For an input level v of 0..1023, the result equals v.
- R3: With `res8_sel`=1, eight bits are resolved and `trial_code[1:0]` stays 0. The result is `trial_code[9:2]` of the final code, placed in `result[7:0]` with `result[9:8]`=0. For input level v, the result equals v/4.
- R4: `sample_en` rises in the cycle after a start is accepted. It stays high for 2, 4, 8 or 16 conversion clocks for `smp_sel` = 0, 1, 2, 3. `trial_code` is 0 while `sample_en` is high.
- R5: `busy` stays high for (sample clocks + 16) conversion clocks, that is 18, 20, 24 or 32 conversion clocks.
- R6: One conversion clock lasts 2×(`prs_sel`+1) bus clocks for `prs_sel` 0..7. Any code with `prs_sel[4]` or `prs_sel[3]` set gives 16 bus clocks.
- R7: `done` is high for exactly one bus clock, in the first cycle with `busy` low after a completed conversion. `result` changes only in that cycle.
- R8: While `pwr_en`=0 a start is ignored. Clearing `pwr_en` during a conversion drops `busy`, `sample_en` and `trial_code` in the next cycle without a `done` pulse, and `result` keeps its previous value.
- R9: A start strobe that arrives while `busy` is high is ignored, and the running conversion keeps its length and result.
- R10: `prs_sel`, `smp_sel` and `res8_sel` are sampled only when a start is accepted. Changing them during a conversion changes neither its timing nor its result.
- R11: The first trial code of every search is 10'h200, the most significant bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable; 0 holds the engine idle |
| start | input | 1 | Start strobe, one bus clock |
| prs_sel | input | 5 | Prescaler code |
| smp_sel | input | 2 | Sample-length code |
| res8_sel | input | 1 | 1 = 8-bit, 0 = 10-bit resolution |
| cmp_in | input | 1 | Comparator: 1 when held input >= trial level |
| trial_code | output | 10 | Trial code to the DAC |
| sample_en | output | 1 | Sample-and-hold tracking enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last completed result, right-aligned |

## Verification
The bench targets the input levels at both ends of the range and next to the half-scale step. A search that visits bits in the wrong order, or keeps a bit on the wrong comparator polarity, returns a wrong code at exactly those levels. It measures busy and sample lengths in bus clocks for every sample code and for reserved prescaler codes. A divider off by one, or one that wraps a reserved code to a short divisor, shows up as a wrong cycle count. It fires start strobes and setting changes during a conversion and drops power part way through. An engine that restarts, re-reads its settings, or lets an aborted search write a result or a done pulse would change the measured length, produce a second pulse, or alter the stored result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int PRS_W     = 5;   // prescaler field width
  localparam int PRS_VAL_W = 3;   // low bits that hold valid codes
  localparam int SMP_W     = 2;   // sample-length code width
  localparam int NB_HI     = 10;  // high-resolution bit count (DAC width)
  localparam int NB_LO     = 8;   // low-resolution bit count
  localparam int SLOTS     = 16;  // non-sample conversion clocks

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_PAD    = 2'd2,
    PH_BITS   = 2'd3
  } sar_phase_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int PRS_W     = 5,
  parameter int PRS_VAL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [PRS_W-1:0] prs_code,
  output logic             tick
);
  localparam int CNT_W = PRS_VAL_W + 1;

  logic [PRS_VAL_W-1:0] eff_code;
  logic [CNT_W-1:0]     limit;
  logic [CNT_W-1:0]     cnt_q;

  // reserved codes fall back to the largest valid divisor
  always_comb begin
    if (|prs_code[PRS_W-1:PRS_VAL_W]) eff_code = '1;
    else                              eff_code = prs_code[PRS_VAL_W-1:0];
    limit = {eff_code, 1'b1};          // divisor - 1 = 2*eff + 1
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt_q <= '0;
    else if (cnt_q == limit)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == limit);

  // R6: divisor is at least two, so ticks never come back to back
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int SMP_W  = 2,
  parameter int NB_MAX = 10,
  parameter int NB_MIN = 8,
  parameter int SLOT_N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic             start,
  input  logic             tick,
  input  logic [SMP_W-1:0] smp_code,
  input  logic             res8,
  output logic             accept,
  output logic             busy_q,
  output logic             sample_q,
  output logic             load,
  output logic             step,
  output logic             last
);
  localparam int CNT_W = $clog2(SLOT_N) + 1;

  sar_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pad_last;
  logic [CNT_W-1:0] bits_last;
  logic [CNT_W-1:0] smp_last;

  always_comb begin
    pad_last  = res8 ? CNT_W'(SLOT_N - NB_MIN - 1) : CNT_W'(SLOT_N - NB_MAX - 1);
    bits_last = res8 ? CNT_W'(NB_MIN - 1) : CNT_W'(NB_MAX - 1);
    smp_last  = CNT_W'((32'd2 << smp_code) - 32'd1);
  end

  assign accept = pwr_en && start && (phase_q == PH_IDLE);
  assign load   = pwr_en && tick && (phase_q == PH_PAD) && (cnt_q == '0);
  assign step   = pwr_en && tick && (phase_q == PH_BITS);
  assign last   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      sample_q <= 1'b0;
    end else if (!pwr_en) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q  <= PH_SAMPLE;
          cnt_q    <= smp_last;
          busy_q   <= 1'b1;
          sample_q <= 1'b1;
        end
        PH_SAMPLE: if (tick) begin
          if (cnt_q == '0) begin
            phase_q  <= PH_PAD;
            cnt_q    <= pad_last;
            sample_q <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_PAD: if (tick) begin
          if (cnt_q == '0) begin
            phase_q <= PH_BITS;
            cnt_q   <= bits_last;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_BITS: if (tick) begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R8: a cleared power enable leaves the engine idle next cycle
  a_r8_power_off_idle: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (!busy_q && !sample_q));
  // R4: sampling only happens inside a conversion
  a_r4_sample_in_busy: assert property (@(posedge clk) disable iff (rst)
    sample_q |-> busy_q);
  // R9: a running conversion only ends by its last step or by power loss
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && pwr_en && !(step && last)) |=> busy_q);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int NB_MAX = 10,
  parameter int NB_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              res8,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  input  logic              comp,
  output logic [NB_MAX-1:0] trial_q,
  output logic [NB_MAX-1:0] result_q,
  output logic              done_q
);
  localparam int LO_SHIFT = NB_MAX - NB_MIN;
  localparam logic [NB_MAX-1:0] MSB_ONLY = {1'b1, {(NB_MAX-1){1'b0}}};

  logic [NB_MAX-1:0] mask_q;
  logic [NB_MAX-1:0] kept;
  logic [NB_MAX-1:0] final_code;

  always_comb begin
    kept       = comp ? trial_q : (trial_q & ~mask_q);
    final_code = res8 ? (kept >> LO_SHIFT) : kept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q  <= '0;
      mask_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        trial_q <= '0;
        mask_q  <= '0;
      end else if (load) begin
        trial_q <= MSB_ONLY;
        mask_q  <= MSB_ONLY;
      end else if (step) begin
        if (last) begin
          result_q <= final_code;
          trial_q  <= '0;
          mask_q   <= '0;
          done_q   <= 1'b1;
        end else begin
          trial_q <= kept | (mask_q >> 1);
          mask_q  <= mask_q >> 1;
        end
      end
    end
  end

  // R7: completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7: the stored result moves only together with the pulse
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(result_q));
  // R11: the search opens at the most significant bit
  a_r11_msb_first: assert property (@(posedge clk) disable iff (rst)
    (load && !abort) |=> (trial_q == MSB_ONLY));
  // R3: low-resolution trials never touch the unused low DAC bits
  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    res8 |-> (trial_q[LO_SHIFT-1:0] == '0));
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic             start,
  input  logic [PRS_W-1:0] prs_sel,
  input  logic [SMP_W-1:0] smp_sel,
  input  logic             res8_sel,
  input  logic             cmp_in,
  output logic [NB_HI-1:0] trial_code,
  output logic             sample_en,
  output logic             busy,
  output logic             done,
  output logic [NB_HI-1:0] result
);
  logic             accept, tick, load, step, last;
  logic [PRS_W-1:0] prs_q;
  logic             res8_q;

  // settings captured once per conversion
  always_ff @(posedge clk) begin
    if (rst) begin
      prs_q  <= '0;
      res8_q <= 1'b0;
    end else if (accept) begin
      prs_q  <= prs_sel;
      res8_q <= res8_sel;
    end
  end

  sar_clk_div #(.PRS_W(PRS_W), .PRS_VAL_W(PRS_VAL_W)) div_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .run      (busy),
    .prs_code (prs_q),
    .tick     (tick)
  );

  sar_sequencer #(.SMP_W(SMP_W), .NB_MAX(NB_HI), .NB_MIN(NB_LO), .SLOT_N(SLOTS)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .pwr_en   (pwr_en),
    .start    (start),
    .tick     (tick),
    .smp_code (smp_sel),
    .res8     (res8_q),
    .accept   (accept),
    .busy_q   (busy),
    .sample_q (sample_en),
    .load     (load),
    .step     (step),
    .last     (last)
  );

  sar_search #(.NB_MAX(NB_HI), .NB_MIN(NB_LO)) srch_i (
    .clk      (clk),
    .rst      (rst),
    .abort    (!pwr_en),
    .res8     (res8_q),
    .load     (load),
    .step     (step),
    .last     (last),
    .comp     (cmp_in),
    .trial_q  (trial_code),
    .result_q (result),
    .done_q   (done)
  );

  // R7: the pulse marks the cycle in which busy has just fallen
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  // R4: no trial level is driven while the input is tracked
  a_r4_no_trial_sampling: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (trial_code == '0));
endmodule

// File: tb/sar_conv_engine_tb.sv
`timescale 1ns/1ps
module sar_conv_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_en = 1'b0;
  logic       start = 1'b0;
  logic [4:0] prs_sel = '0;
  logic [1:0] smp_sel = '0;
  logic       res8_sel = 1'b0;
  logic       cmp_in;
  logic [9:0] trial_code;
  logic       sample_en, busy, done;
  logic [9:0] result;
  logic [9:0] vin = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int m_busy, m_samp, m_done, m_first, m_lowbad;

  always #10 clk = ~clk;

  // analog model: held level vs DAC level
  assign cmp_in = (vin >= trial_code);

  sar_conv_engine dut_i (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .start(start),
    .prs_sel(prs_sel), .smp_sel(smp_sel), .res8_sel(res8_sel),
    .cmp_in(cmp_in), .trial_code(trial_code), .sample_en(sample_en),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_div(input logic [4:0] p);
    return (p[4] || p[3]) ? 16 : 2 * (int'(p[2:0]) + 1);
  endfunction

  // one conversion; optional disturbance at cycle 5
  task automatic run_conv(input logic [4:0] p, input logic [1:0] s, input bit r8,
                          input logic [9:0] v, input bit mid_start, input bit mid_cfg);
    int extra;
    @(negedge clk);
    prs_sel = p; smp_sel = s; res8_sel = r8; vin = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_busy = 0; m_samp = 0; m_done = 0; m_first = -1; m_lowbad = 0; extra = 0;
    for (int k = 0; k < 1500; k++) begin
      if (busy) m_busy++;
      if (sample_en) m_samp++;
      if (done) m_done++;
      if (m_first < 0 && trial_code != 0) m_first = int'(trial_code);
      if (r8 && trial_code[1:0] != 2'b00) m_lowbad++;
      if (k == 5 && mid_start) start = 1'b1;
      if (k == 6) start = 1'b0;
      if (k == 5 && mid_cfg) begin
        prs_sel = 5'd7; smp_sel = 2'd3; res8_sel = ~r8;
      end
      if (m_done > 0) extra++;
      if (extra > 4) break;
      @(negedge clk);
    end
  endtask

  task automatic conv_and_check(input logic [4:0] p, input logic [1:0] s, input bit r8,
                                input logic [9:0] v, input string tag);
    int d, sc, er;
    d = exp_div(p);
    sc = 2 << s;
    er = r8 ? int'(v) / 4 : int'(v);
    run_conv(p, s, r8, v, 1'b0, 1'b0);
    chk(int'(result) == er, {tag, " result (R2/R3)"}, int'(result), er);
    chk(m_busy == (sc + 16) * d, {tag, " busy length R5 R6"}, m_busy, (sc + 16) * d);
    chk(m_samp == sc * d, {tag, " sample length R4"}, m_samp, sc * d);
    chk(m_done == 1, {tag, " single done R7"}, m_done, 1);
    chk(m_first == 'h200, {tag, " first trial R11"}, m_first, 'h200);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 0 && done == 0 && sample_en == 0, "R1 control outputs idle",
        int'({busy, done, sample_en}), 0);
    chk(trial_code == 0 && result == 0, "R1 codes zero", int'(trial_code) + int'(result), 0);
  endtask

  task automatic t_res10;
    conv_and_check(5'd0, 2'd0, 1'b0, 10'h2A5, "R2 mid pattern");
    conv_and_check(5'd0, 2'd0, 1'b0, 10'h000, "R2 zero level");
    conv_and_check(5'd0, 2'd0, 1'b0, 10'h3FF, "R2 full scale");
    conv_and_check(5'd0, 2'd0, 1'b0, 10'h200, "R2 half scale");
    conv_and_check(5'd0, 2'd0, 1'b0, 10'h1FF, "R2 below half");
  endtask

  task automatic t_res8;
    conv_and_check(5'd1, 2'd1, 1'b1, 10'h3FF, "R3 full scale");
    chk(m_lowbad == 0, "R3 low trial bits", m_lowbad, 0);
    conv_and_check(5'd1, 2'd1, 1'b1, 10'h0C7, "R3 mid pattern");
    chk(result[9:8] == 2'b00, "R3 upper result bits", int'(result[9:8]), 0);
    conv_and_check(5'd1, 2'd1, 1'b1, 10'h003, "R3 below one step");
  endtask

  task automatic t_sample_codes;
    conv_and_check(5'd2, 2'd2, 1'b0, 10'h155, "R4 code2");
    conv_and_check(5'd2, 2'd3, 1'b0, 10'h2AA, "R4 code3");
  endtask

  task automatic t_prescaler;
    conv_and_check(5'd7, 2'd0, 1'b0, 10'h0F0, "R6 divisor16");
    conv_and_check(5'b01010, 2'd0, 1'b0, 10'h111, "R6 reserved 01xxx");
    conv_and_check(5'b11000, 2'd0, 1'b1, 10'h222, "R6 reserved 11xxx");
  endtask

  task automatic t_start_busy;
    run_conv(5'd0, 2'd0, 1'b0, 10'h123, 1'b1, 1'b0);
    chk(m_busy == 36, "R9 length kept", m_busy, 36);
    chk(m_done == 1, "R9 one done", m_done, 1);
    chk(int'(result) == 'h123, "R9 result kept", int'(result), 'h123);
  endtask

  task automatic t_latch;
    run_conv(5'd0, 2'd0, 1'b0, 10'h301, 1'b0, 1'b1);
    chk(m_busy == 36, "R10 timing unchanged", m_busy, 36);
    chk(m_samp == 4, "R10 sample unchanged", m_samp, 4);
    chk(int'(result) == 'h301, "R10 resolution unchanged", int'(result), 'h301);
  endtask

  task automatic t_power;
    int seen;
    logic [9:0] prev;
    prev = result;
    @(negedge clk);
    pwr_en = 1'b0; vin = 10'h05A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      if (busy || sample_en || done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R8 start ignored when off", seen, 0);
    pwr_en = 1'b1; prs_sel = 5'd0; smp_sel = 2'd0; res8_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk(busy == 1, "R8 running before abort", int'(busy), 1);
    pwr_en = 1'b0;
    @(negedge clk);
    chk(busy == 0 && sample_en == 0 && trial_code == 0, "R8 abort clears",
        int'({busy, sample_en}) + int'(trial_code), 0);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R8 no done after abort", seen, 0);
    chk(result == prev, "R8 result held", int'(result), int'(prev));
    pwr_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R5 completion) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    pwr_en = 1'b1;
    repeat (2) @(negedge clk);
    t_res10();
    t_res8();
    t_sample_codes();
    t_prescaler();
    t_start_busy();
    t_latch();
    t_power();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule